// File: doc/BRIEF.md
# Sixteen-Bit Multicycle Shared-Bus Processor

This block is a small word-addressed processor with a 16-bit data path. It runs an eight-instruction set. Every transfer inside the core goes over one internal 16-bit bus. The parts on that bus are a sixteen-entry register file, two ALU operand registers (A and B), the program counter, the instruction register, a memory address register, a zero flag and a word memory. A hard-coded state machine picks, in each cycle, the single source that drives the bus and the registers that capture it. It fetches and executes instructions one after another until it meets a halt.

The program is given as a parameter. Each reset copies this image into the low words of the internal memory, and every other word is cleared. Outside the core, a system sees the bus value of each cycle and a halted flag. That is enough to trace execution and to detect the end of a program.

Top module: `mcp_core`

## Requirements
- R1: While reset is held, the PC is 0 and halted is low. In the first cycle after reset the bus carries address 0.
- R2: Each instruction starts with a three-cycle fetch. In the first cycle the bus carries the instruction's own address. In the third cycle the bus carries the PC plus one, which becomes the new PC.
- R3: In the second fetch cycle the bus carries the memory word at the PC. The opcode is in bits 15-13, RX in 12-9 and RY in 8-5. Register-type words hold RZ in bits 3-0. Immediate-type words hold a two's-complement offset in bits 4-0.
- R4: The opcodes are add=000 and nand=001. Each writes RY op RZ into RX and takes 6 cycles. The written value is on the bus in the last cycle.
- R5: Opcode addi=010 writes RY plus the sign-extended offset (-16 to +15) into RX. It takes 6 cycles, and the result is on the bus in the last cycle.
- R6: Opcode lw=011 loads memory[RY+offset] into RX, and sw=100 stores RX at that address. Each takes 7 cycles. In the last cycle the bus carries the word loaded or stored. The address uses the low ADDR_W bits of the sum.
- R7: Opcode beq=101 compares RX with RY. When they are equal, the next PC is the beq address plus 1 plus the offset, the instruction takes 9 cycles, and the target is on the bus in the last cycle. Otherwise it takes 7 cycles and the bus ends on the beq address plus 1.
- R8: Opcode jalr=110 first writes the beq-style return address (its own address plus 1) into RY. It then jumps to the value RX holds after that write, so RX equal to RY continues at the next word. It takes 5 cycles, and the target is on the bus in the last cycle.
- R9: Register 0 always reads as zero. Writes to it are accepted and discarded.
- R10: Opcode halt=111 raises halted in the cycle after its fetch. From then on halted stays high and no state changes.
- R11: No more than one source drives the bus in any cycle. The bus reads zero when none does, including while halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; reloads the program image |
| halted | output | 1 | High once a halt instruction has executed |
| bus_dbg | output | 16 | Value on the internal shared bus in the current cycle |

## Verification
The bench builds the core with ADDR_W=6, a 64-word memory, and a 55-word program. With this configuration the data words written by stores sit just above the program, so they are easy to reach. The program runs addi with all 32 offsets from -16 to +15. It also covers a write to register 0, loads and stores with positive and negative offsets, a taken and an untaken beq, and jalr with distinct and with identical registers. A reference model in the bench predicts the bus value for the first cycle, the second cycle and the last cycle of every instruction, and predicts each instruction's cycle count. Each value is computed arithmetically from the instruction word.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

    localparam int WORD_W = 16;
    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);
    localparam int NSRC   = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_NAND = 3'b001,
        OP_ADDI = 3'b010,
        OP_LW   = 3'b011,
        OP_SW   = 3'b100,
        OP_BEQ  = 3'b101,
        OP_JALR = 3'b110,
        OP_HALT = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_NAND = 2'b01,
        ALU_SUB  = 2'b10,
        ALU_INC  = 2'b11
    } alu_fn_e;

    typedef enum logic [1:0] {
        SEL_RX   = 2'b00,
        SEL_RY   = 2'b01,
        SEL_RZ   = 2'b10,
        SEL_NONE = 2'b11
    } rsel_e;

    typedef struct packed {
        logic    drv_reg;
        logic    drv_mem;
        logic    drv_alu;
        logic    drv_pc;
        logic    drv_off;
        logic    ld_pc;
        logic    ld_ir;
        logic    ld_mar;
        logic    ld_a;
        logic    ld_b;
        logic    ld_z;
        logic    wr_reg;
        logic    wr_mem;
        rsel_e   rsel;
        alu_fn_e alu;
    } ctrl_t;

    typedef enum logic [4:0] {
        S_F0, S_F1, S_F2,
        S_RDY, S_RDZ, S_WB, S_OFFB, S_EA, S_LD, S_ST,
        S_B0, S_B1, S_B2, S_B3, S_B4, S_B5,
        S_J0, S_J1,
        S_HALT
    } state_e;

    function automatic word_t sext5(input logic [4:0] f);
        return {{(WORD_W-5){f[4]}}, f};
    endfunction

    function automatic ridx_t pick_reg(input word_t ir, input rsel_e s);
        case (s)
            SEL_RX:  return ir[12:9];
            SEL_RY:  return ir[8:5];
            SEL_RZ:  return ir[3:0];
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mcp_alu.sv
module mcp_alu
    import mcp_pkg::*;
(
    input  word_t   a,
    input  word_t   b,
    input  alu_fn_e fn,
    output word_t   y
);
    always_comb begin
        case (fn)
            ALU_ADD:  y = a + b;
            ALU_NAND: y = ~(a & b);
            ALU_SUB:  y = a - b;
            default:  y = a + word_t'(1);
        endcase
    end
endmodule

// File: rtl/mcp_regfile.sv
module mcp_regfile
    import mcp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ridx_t idx,
    input  logic  wr_en,
    input  word_t wr_data,
    output word_t rd_data
);
    word_t regs [NREG];

    // entry 0 is a constant; every other entry is a plain register
    assign regs[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && idx == ridx_t'(g))
                regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[idx];
endmodule

// File: rtl/mcp_mem.sv
module mcp_mem
    import mcp_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int PROG_LEN = 1,
    parameter logic [WORD_W*PROG_LEN-1:0] PROGRAM = {PROG_LEN{16'hE000}}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  word_t             wdata,
    output word_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam word_t INIT = (g < PROG_LEN) ? PROGRAM[WORD_W*g +: WORD_W] : '0;
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= INIT;
            else if (we && addr == ADDR_W'(g))
                cells[g] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
    import mcp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_e op,
    input  logic    z,
    output ctrl_t   ctrl,
    output logic    halted,
    output logic    in_fetch2
);
    state_e state_q, nxt;

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_F0;
        else     state_q <= nxt;
    end

    always_comb begin
        ctrl = '0;
        nxt  = state_q;
        case (state_q)
            S_F0: begin ctrl.drv_pc = 1'b1; ctrl.ld_mar = 1'b1; ctrl.ld_a = 1'b1; nxt = S_F1; end
            S_F1: begin ctrl.drv_mem = 1'b1; ctrl.ld_ir = 1'b1; nxt = S_F2; end
            S_F2: begin
                ctrl.drv_alu = 1'b1; ctrl.alu = ALU_INC; ctrl.ld_pc = 1'b1;
                case (op)
                    OP_BEQ:  nxt = S_B0;
                    OP_JALR: nxt = S_J0;
                    OP_HALT: nxt = S_HALT;
                    default: nxt = S_RDY;
                endcase
            end
            S_RDY: begin
                ctrl.rsel = SEL_RY; ctrl.drv_reg = 1'b1; ctrl.ld_a = 1'b1;
                nxt = (op == OP_ADD || op == OP_NAND) ? S_RDZ : S_OFFB;
            end
            S_RDZ: begin ctrl.rsel = SEL_RZ; ctrl.drv_reg = 1'b1; ctrl.ld_b = 1'b1; nxt = S_WB; end
            S_WB: begin
                ctrl.drv_alu = 1'b1; ctrl.alu = (op == OP_NAND) ? ALU_NAND : ALU_ADD;
                ctrl.rsel = SEL_RX; ctrl.wr_reg = 1'b1; nxt = S_F0;
            end
            S_OFFB: begin
                ctrl.drv_off = 1'b1; ctrl.ld_b = 1'b1;
                nxt = (op == OP_ADDI) ? S_WB : S_EA;
            end
            S_EA: begin
                ctrl.drv_alu = 1'b1; ctrl.alu = ALU_ADD; ctrl.ld_mar = 1'b1;
                nxt = (op == OP_LW) ? S_LD : S_ST;
            end
            S_LD: begin ctrl.drv_mem = 1'b1; ctrl.rsel = SEL_RX; ctrl.wr_reg = 1'b1; nxt = S_F0; end
            S_ST: begin ctrl.drv_reg = 1'b1; ctrl.rsel = SEL_RX; ctrl.wr_mem = 1'b1; nxt = S_F0; end
            S_B0: begin ctrl.rsel = SEL_RX; ctrl.drv_reg = 1'b1; ctrl.ld_a = 1'b1; nxt = S_B1; end
            S_B1: begin ctrl.rsel = SEL_RY; ctrl.drv_reg = 1'b1; ctrl.ld_b = 1'b1; nxt = S_B2; end
            S_B2: begin ctrl.drv_alu = 1'b1; ctrl.alu = ALU_SUB; ctrl.ld_z = 1'b1; nxt = S_B3; end
            S_B3: begin ctrl.drv_pc = 1'b1; ctrl.ld_a = 1'b1; nxt = z ? S_B4 : S_F0; end
            S_B4: begin ctrl.drv_off = 1'b1; ctrl.ld_b = 1'b1; nxt = S_B5; end
            S_B5: begin ctrl.drv_alu = 1'b1; ctrl.alu = ALU_ADD; ctrl.ld_pc = 1'b1; nxt = S_F0; end
            S_J0: begin ctrl.drv_pc = 1'b1; ctrl.rsel = SEL_RY; ctrl.wr_reg = 1'b1; nxt = S_J1; end
            S_J1: begin ctrl.rsel = SEL_RX; ctrl.drv_reg = 1'b1; ctrl.ld_pc = 1'b1; nxt = S_F0; end
            S_HALT: nxt = S_HALT;
            default: nxt = S_F0;
        endcase
    end

    assign halted    = (state_q == S_HALT);
    assign in_fetch2 = (state_q == S_F2);
endmodule

// File: rtl/mcp_core.sv
module mcp_core
    import mcp_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int PROG_LEN = 1,
    parameter logic [WORD_W*PROG_LEN-1:0] PROGRAM = {PROG_LEN{16'hE000}}
) (
    input  logic        clk,
    input  logic        rst,
    output logic        halted,
    output logic [15:0] bus_dbg
);
    ctrl_t             ctrl;
    word_t             bus;
    word_t             pc_q, ir_q, a_q, b_q;
    logic [ADDR_W-1:0] mar_q;
    logic              z_q;
    word_t             rf_rd, mem_rd, alu_y;
    ridx_t             rf_idx;
    logic              in_fetch2;
    logic [NSRC-1:0]   drv_vec;
    word_t             src    [NSRC];
    logic              rf_zero_read;

    mcp_ctrl u_ctrl (
        .clk(clk), .rst(rst), .op(opcode_e'(ir_q[15:13])), .z(z_q),
        .ctrl(ctrl), .halted(halted), .in_fetch2(in_fetch2)
    );

    assign rf_idx = pick_reg(ir_q, ctrl.rsel);

    mcp_regfile u_rf (
        .clk(clk), .rst(rst), .idx(rf_idx),
        .wr_en(ctrl.wr_reg), .wr_data(bus), .rd_data(rf_rd)
    );

    mcp_alu u_alu (.a(a_q), .b(b_q), .fn(ctrl.alu), .y(alu_y));

    mcp_mem #(.ADDR_W(ADDR_W), .PROG_LEN(PROG_LEN), .PROGRAM(PROGRAM)) u_mem (
        .clk(clk), .rst(rst), .addr(mar_q), .we(ctrl.wr_mem),
        .wdata(bus), .rdata(mem_rd)
    );

    // shared bus: each source gated by its own enable, results merged
    assign drv_vec = {ctrl.drv_reg, ctrl.drv_mem, ctrl.drv_alu, ctrl.drv_pc, ctrl.drv_off};
    assign src[4]  = rf_rd;
    assign src[3]  = mem_rd;
    assign src[2]  = alu_y;
    assign src[1]  = pc_q;
    assign src[0]  = sext5(ir_q[4:0]);

    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++)
            bus |= src[i] & {WORD_W{drv_vec[i]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            mar_q <= '0;
            z_q   <= 1'b0;
        end else begin
            if (ctrl.ld_pc)  pc_q  <= bus;
            if (ctrl.ld_ir)  ir_q  <= bus;
            if (ctrl.ld_a)   a_q   <= bus;
            if (ctrl.ld_b)   b_q   <= bus;
            if (ctrl.ld_mar) mar_q <= bus[ADDR_W-1:0];
            if (ctrl.ld_z)   z_q   <= (bus == '0);
        end
    end

    assign rf_zero_read = ctrl.drv_reg && (rf_idx == '0);
    assign bus_dbg      = bus;
endmodule

// File: rtl/mcp_core_chk.sv
module mcp_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        halted,
    input logic [15:0] bus,
    input logic [4:0]  drv,
    input logic [15:0] pc,
    input logic        in_fetch2,
    input logic        rf_zero_read
);
    p_single_driver_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv));

    p_idle_bus_r11: assert property (@(posedge clk) disable iff (rst)
        (drv == 5'b0) |-> (bus == 16'h0000));

    p_reg_zero_reads_r9: assert property (@(posedge clk) disable iff (rst)
        rf_zero_read |-> (bus == 16'h0000));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        in_fetch2 |=> (pc == 16'($past(pc) + 16'd1)));

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc));
endmodule

bind mcp_core mcp_core_chk u_chk (
    .clk(clk), .rst(rst), .halted(halted), .bus(bus_dbg), .drv(drv_vec),
    .pc(pc_q), .in_fetch2(in_fetch2), .rf_zero_read(rf_zero_read)
);

// File: tb/mcp_core_test.sv
`timescale 1ns/1ps
module mcp_core_test;
    localparam int AW = 6;
    localparam int MW = 1 << AW;
    localparam int PL = 55;

    function automatic logic [15:0] enc_r(input int op, input int rx, input int ry, input int rz);
        return {3'(op), 4'(rx), 4'(ry), 1'b0, 4'(rz)};
    endfunction

    function automatic logic [15:0] enc_i(input int op, input int rx, input int ry, input int off);
        logic [31:0] o;
        o = 32'(off);
        return {3'(op), 4'(rx), 4'(ry), o[4:0]};
    endfunction

    function automatic logic [16*PL-1:0] build_prog();
        logic [15:0] w [PL];
        logic [16*PL-1:0] v;
        w[0] = enc_i(2, 2, 0, 5);
        w[1] = enc_i(2, 3, 0, -3);
        w[2] = enc_r(0, 4, 2, 3);
        w[3] = enc_r(1, 5, 2, 3);
        w[4] = enc_i(2, 0, 2, 7);
        w[5] = enc_r(0, 6, 0, 0);
        for (int k = -16; k <= 15; k++) w[22 + k] = enc_i(2, 7, 2, k);
        w[38] = enc_i(2, 8, 0, 15);
        w[39] = enc_i(2, 8, 8, 15);
        w[40] = enc_i(2, 8, 8, 15);
        w[41] = enc_i(2, 8, 8, 12);
        w[42] = enc_i(4, 5, 8, 3);
        w[43] = enc_i(3, 9, 8, 3);
        w[44] = enc_i(4, 4, 8, -1);
        w[45] = enc_i(3, 10, 8, -1);
        w[46] = enc_i(5, 9, 5, 1);
        w[47] = enc_i(2, 11, 0, 1);
        w[48] = enc_i(5, 2, 3, 5);
        w[49] = enc_i(2, 12, 8, -6);
        w[50] = enc_i(6, 12, 15, 0);
        w[51] = enc_i(6, 13, 13, 0);
        w[52] = enc_i(5, 0, 0, 1);
        w[53] = enc_i(2, 1, 0, 1);
        w[54] = 16'hE000;
        for (int i = 0; i < PL; i++) v[16*i +: 16] = w[i];
        return v;
    endfunction

    localparam logic [16*PL-1:0] PROG = build_prog();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halted;
    logic [15:0] bus_dbg;
    int          checks = 0;
    int          errors = 0;
    bit          fin = 1'b0;

    always #2.5 clk = ~clk;

    mcp_core #(.ADDR_W(AW), .PROG_LEN(PL), .PROGRAM(PROG)) uut (
        .clk(clk), .rst(rst), .halted(halted), .bus_dbg(bus_dbg)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic [15:0] sx(input logic [4:0] f);
        return {{11{f[4]}}, f};
    endfunction

    logic [15:0] mref [MW];
    logic [15:0] rref [16];

    function automatic logic [15:0] rd(input logic [3:0] i);
        return (i == 4'd0) ? 16'h0000 : rref[i];
    endfunction

    initial begin
        logic [15:0] pc, ir, off, npc, last, val;
        logic [2:0]  op;
        logic [3:0]  rx, ry, rz;
        int          ncyc;
        string       tag;
        for (int i = 0; i < MW; i++) mref[i] = (i < PL) ? PROG[16*i +: 16] : 16'h0000;
        for (int i = 0; i < 16; i++) rref[i] = 16'h0000;
        pc = 16'h0000;

        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(bus_dbg == 16'h0000, "R1 bus shows PC 0 in reset", bus_dbg, 16'h0000);
        chk(halted == 1'b0, "R1 halted low in reset", {15'd0, halted}, 16'h0000);
        rst = 1'b0;
        #1;
        chk(bus_dbg == 16'h0000, "R1 first fetch address", bus_dbg, 16'h0000);

        for (int step = 0; step < 400 && !fin; step++) begin
            ir  = mref[pc[AW-1:0]];
            op  = ir[15:13]; rx = ir[12:9]; ry = ir[8:5]; rz = ir[3:0];
            off = sx(ir[4:0]);
            npc = pc + 16'd1;
            chk(bus_dbg == pc, "R2 fetch address on bus", bus_dbg, pc);
            chk(halted == 1'b0, "R10 halted low while running", {15'd0, halted}, 16'h0000);
            @(negedge clk); #1;
            chk(bus_dbg == ir, "R3 instruction word on bus", bus_dbg, ir);
            if (op == 3'b111) begin
                @(negedge clk); #1;
                chk(bus_dbg == npc, "R2 incremented PC", bus_dbg, npc);
                for (int h = 0; h < 5; h++) begin
                    @(negedge clk); #1;
                    chk(halted == 1'b1, "R10 halted after halt", {15'd0, halted}, 16'h0001);
                    chk(bus_dbg == 16'h0000, "R11 bus idle while halted", bus_dbg, 16'h0000);
                end
                fin = 1'b1;
            end else begin
                case (op)
                    3'b000: begin val = rd(ry) + rd(rz); last = val; ncyc = 6; tag = "R4 add result"; end
                    3'b001: begin val = ~(rd(ry) & rd(rz)); last = val; ncyc = 6; tag = "R4 nand result"; end
                    3'b010: begin val = rd(ry) + off; last = val; ncyc = 6; tag = "R5 addi result"; end
                    3'b011: begin val = mref[AW'(rd(ry) + off)]; last = val; ncyc = 7; tag = "R6 lw data"; end
                    3'b100: begin val = rd(rx); last = val; ncyc = 7; tag = "R6 sw data"; end
                    3'b101: begin
                        if (rd(rx) == rd(ry)) begin last = npc + off; ncyc = 9; tag = "R7 beq taken target"; end
                        else begin last = npc; ncyc = 7; tag = "R7 beq not taken"; end
                        val = 16'h0000;
                    end
                    default: begin val = npc; last = 16'h0000; ncyc = 5; tag = "R8 jalr target"; end
                endcase
                // state update of the reference model
                case (op)
                    3'b000, 3'b001, 3'b010, 3'b011: begin if (rx != 4'd0) rref[rx] = val; pc = npc; end
                    3'b100: begin mref[AW'(rd(ry) + off)] = val; pc = npc; end
                    3'b101: pc = last;
                    default: begin
                        if (ry != 4'd0) rref[ry] = val;
                        last = rd(rx);
                        pc = last;
                    end
                endcase
                if (op == 3'b000 && rx == 4'd0) tag = "R9 write to register 0";
                repeat (ncyc - 2) @(negedge clk);
                #1;
                chk(bus_dbg == last, tag, bus_dbg, last);
                @(negedge clk); #1;
            end
        end
        // register 0 still zero and jalr same-register case reached PC+1
        chk(rd(4'd0) == 16'h0000, "R9 model register 0", rd(4'd0), 16'h0000);
        chk(rref[13] == 16'd52, "R8 same-register jalr link", rref[13], 16'd52);
        chk(fin == 1'b1, "R10 program reached halt", {15'd0, fin}, 16'h0001);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=running expected=halted");
        end
        report();
    end
endmodule